// File: doc/BRIEF.md
# Multi-Channel Shadowed PWM Generator

This block drives a parameterised number of pulse-width outputs from one clock. Each channel runs a counter over a period measured in clock cycles. Within each period it raises its output for a programmed number of cycles (the high time), starting at a programmed phase offset. Software reaches the block through a simple 32-bit word register port: one write strobe, a byte address and write data. Read data is a combinational function of the address.

New period, high-time and offset values go into shadow storage first. They are copied into the running channels only when a load command is written to the control word. That copy also restarts every channel counter at cycle zero, so all outputs come out phase-aligned. An alignment option in the configuration word chooses when the copy happens:
- With alignment forced, the load takes effect at once.
- Otherwise it waits until every running channel has completed its current period.

A halt bit in the control word stops all channels and keeps every output low.

Top module: `pwm_bank`

## Requirements
- R1: Reading word 0x0C returns 0x601A3471, word 0x14 returns the number of channels, and word 0x04 returns the VERSION parameter. Word 0x08 is a scratch register that reads back what was written. Writes to the read-only words have no effect.
- R2: Channel n's period is at 0x40+4n, its high time at 0x80+4n and its offset at 0xC0+4n. Reads return the shadow value. Writing these words changes no output until a load is applied.
- R3: With bit 1 of the configuration word (0x18) set, writing 1 to bit 1 of the control word (0x10) applies all shadow values at that clock edge. It also restarts every channel counter at zero, so the outputs follow the new values from cycle 0, aligned across channels.
- R4: With configuration bit 1 clear (the reset value), a load waits until every channel with a nonzero period has reached the last cycle of its period at least once after the load was written. At the edge where the last of them does so, the load is applied and all counters restart at zero. Until then the outputs keep their old pattern. Channels with period 0 do not delay the load.
- R5: With period P, high time D and offset O, the output in counter cycle c is 1 when ((c − O) mod P) < D, so the high pulse wraps past the end of the period. The output is registered: in the k-th clock after an apply edge (k ≥ 1) it shows counter cycle (k−1) mod P.
- R6: A high time equal to or larger than the period gives a constant high output. A high time of 0 gives a constant low output.
- R7: An offset equal to or larger than the period keeps the output low.
- R8: A period of 0 disables the channel, and its output stays low.
- R9: Bit 0 of the control word is a halt bit. It reads back, is 1 after reset, and while it is 1 every output is low and the counters are held at zero. A load written while halted applies immediately. The load bit itself always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and all counters |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address; bits 1:0 are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | NUM_CH | Registered channel outputs, active high |

## Verification
The collision of interest is a deferred load completing at the very edge where the last running channel wraps its counter. Channels that finished earlier are mid-period at that edge and must be cut short and restarted together with it. The bench provokes this by writing a deferred load at an arbitrary cycle while the channels run periods of 7, 4 and 3, alongside one disabled channel. It predicts the apply edge from each period's remaining cycles and checks the old pattern up to that edge and the new aligned pattern after it, cycle by cycle. A second overlap is a load written while the block is halted, which must take effect even though no counter is running.

// File: rtl/pwm_bank_pkg.sv
// Shared constants for the PWM bank: register slots, banks and bit positions.
package pwm_bank_pkg;
    localparam int         REG_W      = 32;
    localparam int         ADDR_W     = 8;
    localparam int         SLOT_W     = 4;
    localparam logic [31:0] MAGIC_WORD = 32'h601A_3471;

    // Upper two address bits select a bank of 16 words.
    typedef enum logic [1:0] {
        BANK_GLOBAL = 2'b00,
        BANK_PERIOD = 2'b01,
        BANK_HIGH   = 2'b10,
        BANK_PHASE  = 2'b11
    } bank_e;

    // Word slots inside the global bank.
    localparam logic [SLOT_W-1:0] SLOT_VERSION = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_SCRATCH = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_MAGIC   = 4'd3;
    localparam logic [SLOT_W-1:0] SLOT_CTRL    = 4'd4;
    localparam logic [SLOT_W-1:0] SLOT_COUNT   = 4'd5;
    localparam logic [SLOT_W-1:0] SLOT_CONFIG  = 4'd6;

    localparam int CTRL_HALT_BIT    = 0;
    localparam int CTRL_LOAD_BIT    = 1;
    localparam int CONFIG_ALIGN_BIT = 1;
endpackage

// File: rtl/pwm_regs.sv
// Register port and shadow storage.
// Decodes single-cycle word writes, holds the shadow period/high/phase values
// and the global control bits, and returns read data combinationally.
// Assumes NUM_CH <= 16 and CNT_W <= 32. The load bit is a pulse that is never stored.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0002_0100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output logic [NUM_CH-1:0][CNT_W-1:0] sh_per,
    output logic [NUM_CH-1:0][CNT_W-1:0] sh_high,
    output logic [NUM_CH-1:0][CNT_W-1:0] sh_phase,
    output logic                         core_rst,
    output logic                         force_align,
    output logic                         load_req
);
    bank_e             bank;
    logic [SLOT_W-1:0] slot;
    logic              glb_wr;
    logic [REG_W-1:0]  scratch_q;
    logic              unused_lsb;

    assign bank       = bank_e'(addr[7:6]);
    assign slot       = addr[5:2];
    assign unused_lsb = ^addr[1:0];
    assign glb_wr     = wr_en && (bank == BANK_GLOBAL);
    assign load_req   = glb_wr && (slot == SLOT_CTRL) && wdata[CTRL_LOAD_BIT];

    // Purpose: global writable words (scratch, halt, alignment option).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q   <= '0;
            core_rst    <= 1'b1;
            force_align <= 1'b0;
        end else if (glb_wr) begin
            case (slot)
                SLOT_SCRATCH: scratch_q   <= wdata;
                SLOT_CTRL:    core_rst    <= wdata[CTRL_HALT_BIT];
                SLOT_CONFIG:  force_align <= wdata[CONFIG_ALIGN_BIT];
                default:      ;
            endcase
        end
    end

    // Purpose: per-channel shadow words; slots beyond NUM_CH are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per   <= '0;
            sh_high  <= '0;
            sh_phase <= '0;
        end else if (wr_en && (bank != BANK_GLOBAL)) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (slot == SLOT_W'(i)) begin
                    case (bank)
                        BANK_PERIOD: sh_per[i]   <= wdata[CNT_W-1:0];
                        BANK_HIGH:   sh_high[i]  <= wdata[CNT_W-1:0];
                        BANK_PHASE:  sh_phase[i] <= wdata[CNT_W-1:0];
                        default:     ;
                    endcase
                end
            end
        end
    end

    // Purpose: combinational read multiplexer.
    always_comb begin
        rdata = '0;
        if (bank == BANK_GLOBAL) begin
            case (slot)
                SLOT_VERSION: rdata = VERSION;
                SLOT_SCRATCH: rdata = scratch_q;
                SLOT_MAGIC:   rdata = MAGIC_WORD;
                SLOT_CTRL:    rdata[CTRL_HALT_BIT] = core_rst;
                SLOT_COUNT:   rdata = REG_W'(NUM_CH);
                SLOT_CONFIG:  rdata[CONFIG_ALIGN_BIT] = force_align;
                default:      rdata = '0;
            endcase
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (slot == SLOT_W'(i)) begin
                    case (bank)
                        BANK_PERIOD: rdata = REG_W'(sh_per[i]);
                        BANK_HIGH:   rdata = REG_W'(sh_high[i]);
                        default:     rdata = REG_W'(sh_phase[i]);
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pwm_sync_load.sv
// Decides the edge at which shadow values become active.
// A forced (or halted) load applies in the cycle it is written. A deferred
// load waits, with one sticky flag per channel, until every channel has
// reached its end of period; disabled channels report end continuously.
module pwm_sync_load #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic              force_align,
    input  logic              core_rst,
    input  logic [NUM_CH-1:0] ch_end,
    output logic              apply,
    output logic              pending
);
    logic [NUM_CH-1:0] done_q;
    logic [NUM_CH-1:0] done_eff;
    logic              go_now;
    logic              wait_over;

    assign done_eff  = done_q | ch_end;
    assign go_now    = load_req && (force_align || core_rst);
    assign wait_over = pending && (core_rst || (&done_eff));
    assign apply     = go_now || wait_over;

    // Purpose: remember an outstanding deferred load.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending || load_req) && !apply;
    end

    // Purpose: collect which channels have finished a period while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                    done_q <= '0;
        else if (pending && !apply)    done_q <= done_eff;
        else                           done_q <= '0;
    end
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: active copy of the settings, cycle counter and a
// registered output comparator. The high window starts at the phase
// offset and wraps past the period end. Assumes the counter stays below
// the active period, which the restart on apply guarantees.
module pwm_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_rst,
    input  logic             apply,
    input  logic [CNT_W-1:0] sh_per,
    input  logic [CNT_W-1:0] sh_high,
    input  logic [CNT_W-1:0] sh_phase,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_high,
    output logic [CNT_W-1:0] act_phase,
    output logic [CNT_W-1:0] cnt,
    output logic             ch_end,
    output logic             pwm_o
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] rel;
    logic [CNT_W-1:0] high_clamp;
    logic             level;

    assign ch_end = (act_per == '0) || (cnt == act_per - 1'b1);

    // Purpose: take over the shadow values on an apply strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_per   <= '0;
            act_high  <= '0;
            act_phase <= '0;
        end else if (apply) begin
            act_per   <= sh_per;
            act_high  <= sh_high;
            act_phase <= sh_phase;
        end
    end

    // Purpose: period counter, restarted by halt, apply or end of period.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst || apply) cnt <= '0;
        else if (ch_end)                 cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    // Purpose: position inside the period relative to the phase offset.
    always_comb begin
        high_clamp = (act_high > act_per) ? act_per : act_high;
        if (cnt >= act_phase)
            rel = {1'b0, cnt} - {1'b0, act_phase};
        else
            rel = {1'b0, cnt} + {1'b0, act_per} - {1'b0, act_phase};
        level = (act_per != '0) && (act_phase < act_per) && (rel < {1'b0, high_clamp});
    end

    // Purpose: registered output, forced low while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst) pwm_o <= 1'b0;
        else                    pwm_o <= level;
    end
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register port, load sequencer and one channel
// instance per output. All logic runs on clk with a synchronous
// active-low reset; inputs are assumed synchronous to clk.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h0002_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][CNT_W-1:0] sh_per, sh_high, sh_phase;
    logic [NUM_CH-1:0][CNT_W-1:0] act_per, act_high, act_phase, cnt;
    logic [NUM_CH-1:0]            ch_end;
    logic                         core_rst, force_align, load_req;
    logic                         apply, pending;

    pwm_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .VERSION(VERSION)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .sh_per(sh_per), .sh_high(sh_high), .sh_phase(sh_phase),
        .core_rst(core_rst), .force_align(force_align), .load_req(load_req)
    );

    pwm_sync_load #(.NUM_CH(NUM_CH)) load_i (
        .clk(clk), .rst_n(rst_n), .load_req(load_req),
        .force_align(force_align), .core_rst(core_rst), .ch_end(ch_end),
        .apply(apply), .pending(pending)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan #(.CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .apply(apply),
            .sh_per(sh_per[g]), .sh_high(sh_high[g]), .sh_phase(sh_phase[g]),
            .act_per(act_per[g]), .act_high(act_high[g]), .act_phase(act_phase[g]),
            .cnt(cnt[g]), .ch_end(ch_end[g]), .pwm_o(pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
// Assertion checker for pwm_bank, attached with bind below.
// Observes outputs, control state and the active channel settings.
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic                         core_rst,
    input logic                         force_align,
    input logic                         load_req,
    input logic                         pending,
    input logic                         apply,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_per,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_high,
    input logic [NUM_CH-1:0][CNT_W-1:0] act_phase,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (pwm_out == '0)); // R9
    AST_APPLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> ((load_req && (force_align || core_rst)) || pending)); // R4
    AST_FORCE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && force_align) |-> apply); // R3
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (cnt == '0)); // R3
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_per) && $stable(act_high) && $stable(act_phase))); // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act_per[g] == '0) |=> !pwm_out[g]); // R8
        AST_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act_phase[g] >= act_per[g]) |=> !pwm_out[g]); // R7
        AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (!core_rst && act_per[g] != '0 && act_phase[g] == '0 &&
             act_high[g] >= act_per[g]) |=> pwm_out[g]); // R6
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .core_rst(core_rst),
    .force_align(force_align), .load_req(load_req), .pending(pending),
    .apply(apply), .act_per(act_per), .act_high(act_high),
    .act_phase(act_phase), .cnt(cnt)
);

// File: tb/pwm_bank_tb_top.sv
// Scoreboard bench: driver tasks push expected output words into a queue,
// a monitor pops one per clock at the falling edge and compares.
module pwm_bank_tb_top;
    localparam int NCH = 4;
    localparam logic [31:0] VER = 32'h0002_0100;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr;
    logic [7:0]        addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NCH-1:0]    pwm_out;

    always #4 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .CNT_W(32), .VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .pwm_out(pwm_out)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int base   = 0;
    bit done_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    int unsigned s_per[NCH], s_high[NCH], s_phase[NCH];
    int unsigned a_per[NCH], a_high[NCH], a_phase[NCH];

    bit [NCH-1:0] qv[$];
    bit [NCH-1:0] qm[$];
    string        qt[$];

    // Expected level of one channel in counter cycle c.
    function automatic bit wave(int unsigned c, int unsigned p, int unsigned d, int unsigned o);
        longint unsigned rel;
        longint unsigned dc;
        if (p == 0) return 1'b0;
        if (o >= p) return 1'b0;
        dc  = (d > p) ? p : d;
        rel = (longint'(c) + p - o) % p;
        return rel < dc;
    endfunction

    function automatic string cls(int ch);
        if (a_per[ch] == 0)           return "R8";
        if (a_phase[ch] >= a_per[ch]) return "R7";
        if (a_high[ch] >= a_per[ch] || a_high[ch] == 0) return "R6";
        return "R5";
    endfunction

    task automatic push(bit [NCH-1:0] v, bit [NCH-1:0] m, string t);
        qv.push_back(v);
        qm.push_back(m);
        qt.push_back(t);
    endtask

    // Expected outputs for edges base+j0 .. base+j1 under the active model.
    task automatic push_run(int j0, int j1, string t);
        for (int j = j0; j <= j1; j++) begin
            bit [NCH-1:0] v;
            string tg;
            tg = t;
            for (int ch = 0; ch < NCH; ch++) begin
                int unsigned c;
                c = (a_per[ch] == 0) ? 0 : (j - 1) % a_per[ch];
                v[ch] = wave(c, a_per[ch], a_high[ch], a_phase[ch]);
                if (t == "") tg = {tg, " ", cls(ch)};
            end
            push(v, '1, tg);
        end
    endtask

    task automatic drain();
        while (qv.size() != 0) @(posedge clk);
    endtask

    task automatic write_reg(logic [7:0] a, logic [31:0] d);
        @(posedge clk);
        #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr = 1'b0;
        if (a[7:6] != 2'b00 && a[5:2] < NCH) begin
            case (a[7:6])
                2'b01:   s_per[a[5:2]]   = d;
                2'b10:   s_high[a[5:2]]  = d;
                default: s_phase[a[5:2]] = d;
            endcase
        end
    endtask

    task automatic read_chk(logic [7:0] a, logic [31:0] exp, string t);
        @(posedge clk);
        #1;
        addr = a;
        @(negedge clk);
        checks++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", t, a, rdata, exp);
        end
    endtask

    task automatic take_shadow();
        for (int ch = 0; ch < NCH; ch++) begin
            a_per[ch] = s_per[ch]; a_high[ch] = s_high[ch]; a_phase[ch] = s_phase[ch];
        end
    endtask

    // Monitor: compare one expected word per clock.
    always @(negedge clk) begin
        if (qv.size() != 0) begin
            bit [NCH-1:0] v, m;
            string t;
            v = qv.pop_front(); m = qm.pop_front(); t = qt.pop_front();
            if (m != '0) begin
                checks++;
                if ((pwm_out & m) !== (v & m)) begin
                    fails++;
                    $display("FAIL %s cycle %0d actual=%b expected=%b", t, cyc, pwm_out, v);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int L, mx;
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            s_per[ch] = 0; s_high[ch] = 0; s_phase[ch] = 0;
        end
        take_shadow();
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pwm_out !== '0) begin
            fails++;
            $display("FAIL R9 reset outputs actual=%b expected=0", pwm_out);
        end
        read_chk(8'h10, 32'h1, "R9");           // halted after reset
        read_chk(8'h18, 32'h0, "R4");           // deferred mode by default
        read_chk(8'h0C, 32'h601A_3471, "R1");
        read_chk(8'h14, NCH, "R1");
        read_chk(8'h04, VER, "R1");
        write_reg(8'h08, 32'hA5A5_1234);
        read_chk(8'h08, 32'hA5A5_1234, "R1");
        write_reg(8'h0C, 32'h0);
        read_chk(8'h0C, 32'h601A_3471, "R1");   // read-only word unchanged

        // Settings A: normal, clamped high, phase out of range, disabled.
        write_reg(8'h40, 5); write_reg(8'h80, 2); write_reg(8'hC0, 1);
        write_reg(8'h44, 4); write_reg(8'h84, 9); write_reg(8'hC4, 0);
        write_reg(8'h48, 6); write_reg(8'h88, 3); write_reg(8'hC8, 6);
        write_reg(8'h4C, 0); write_reg(8'h8C, 1); write_reg(8'hCC, 0);
        read_chk(8'h84, 9, "R2");

        // R9: load while halted applies at once, outputs stay low.
        write_reg(8'h10, 32'h3);
        take_shadow();
        push('0, '0, "");
        for (int i = 0; i < 4; i++) push('0, '1, "R9");
        drain();
        read_chk(8'h10, 32'h1, "R9");           // load bit reads 0

        // Release halt: channels start from cycle 0 (R5 R6 R7 R8).
        write_reg(8'h10, 32'h0);
        base = cyc;
        push('0, '0, "");
        push_run(1, 24, "");
        drain();

        // R2: shadow writes alone leave the running pattern unchanged.
        write_reg(8'h40, 7); write_reg(8'h80, 3); write_reg(8'hC0, 5);
        write_reg(8'h84, 0);
        push_run(cyc - base, cyc - base + 14, "R2");
        drain();
        read_chk(8'h40, 7, "R2");

        // R3: forced load, wrapping phase window on channel 0.
        write_reg(8'h18, 32'h2);
        read_chk(8'h18, 32'h2, "R3");
        write_reg(8'h10, 32'h2);
        base = cyc;
        take_shadow();
        push('0, '0, "");
        push_run(1, 21, "");
        drain();

        // R3: second forced load mid-period realigns every channel.
        write_reg(8'h48, 3); write_reg(8'h88, 1); write_reg(8'hC8, 2);
        @(posedge clk);
        write_reg(8'h10, 32'h2);
        base = cyc;
        take_shadow();
        push('0, '0, "");
        push_run(1, 18, "R3");
        drain();

        // R4: deferred load waits for the last running channel to wrap.
        write_reg(8'h18, 32'h0);
        write_reg(8'h80, 1);
        write_reg(8'h10, 32'h2);
        L  = cyc - base;
        mx = 0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (a_per[ch] != 0) begin
                int m;
                m = a_per[ch] - (L % a_per[ch]);
                if (m > mx) mx = m;
            end
        end
        push_run(L, L + mx, "R4");
        base = base + L + mx;
        take_shadow();
        push_run(1, 18, "R4");
        drain();

        // R9: halt again drives all outputs low.
        write_reg(8'h10, 32'h1);
        push('0, '0, "");
        for (int i = 0; i < 4; i++) push('0, '1, "R9");
        drain();
        read_chk(8'h10, 32'h1, "R9");

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule